// File: doc/BRIEF.md
# Function Event Queue Controller

This block keeps a first-in first-out queue of pending events for a small table of I/O function slots. It hands those events to a host one record at a time. An external requester posts error events through a valid/ready port. Each error event carries a function handle, a function id, a 16-bit event code, a 64-bit faulting address and a 32-bit qualifier word. A plug command port attaches and detaches functions. For each plug or unplug command, an internal sequencer posts a fixed series of availability events, which carry only the id, the handle and the code. Every event that enters the queue raises a one-cycle notification pulse toward the host.

The host pops records with a single-cycle request. The reply comes in a fixed response layout together with a return code, and a level output shows whether any event is still queued. A separate configure/deconfigure command port changes a slot's configured state. It answers every request with a response code, and it never queues anything. When the queue is full, a new post is dropped and a sticky overflow flag is set. The host clears that flag with a pulse.

Back-pressure on the error port comes only from the plug sequencer. The sequencer's events take priority, so `err_ready` is low on every cycle in which the sequencer is emitting. A queue that is full does not stall the port. The post is accepted and then dropped. The plug port's `hp_ready` is low while the sequencer still holds events to emit.

Top module: `fn_event_queue`

## Requirements
- R1: Each queued record has class 1 (error) or class 2 (availability), and `rsp_class` reports it. No other class ever enters the queue. After reset, `rsp_class` is 0.
- R2: An error response carries the posted id, handle, code, address and qualifier. An availability response carries the id, the handle and the code, and shows address 0 and qualifier 0.
- R3: When `pop_req` is high and the queue is not empty, the oldest record appears on the response outputs in the next cycle, with `rsp_rc`=0. When the queue is empty, `rsp_rc` becomes 1 and every other response output keeps its value. `pending` is high exactly while the queue holds a record. After reset, `rsp_rc` is 1.
- R4: `notify` is high for exactly one cycle, in the cycle after each post that enters the queue, and is low otherwise.
- R5: A hot plug of slot s sets the slot's id to s and its handle to s OR 0x8000_0000, and marks the slot configured. It then posts two availability events in the two following cycles: code 0x0302 first, then code 0x0301. A cold attach (`hp_hot`=0) sets the same state and posts no event.
- R6: An unplug of a configured slot posts code 0x0304 and then code 0x0308. An unplug of an unconfigured slot posts only 0x0308. Both events carry the slot's handle and id from before the unplug. The unplug then sets the handle, the id and the configured state to zero.
- R7: A configure request (`cfg_on`=1) or deconfigure request (`cfg_on`=0) sets `cfg_done` for one cycle, in the following cycle, with a code on `cfg_rc`. The code is 1 ("no action") when the request matches the current state. It is 0 ("done") when the request is the opposite, and the state toggles. It is 2 ("unknown id") when no present slot has that id.
- R8: A slot is present only while its handle is nonzero. A configure request for the id of an unplugged slot returns 2.
- R9: With DEPTH records queued and no pop in the same cycle, a post is dropped. The drop sets `overflow`, which stays high until an `ovf_clr` pulse.
- R10: A post and a pop in the same cycle both complete, even when the queue is full. The number of queued records stays the same and no overflow is raised.
- R11: `err_ready` and `hp_ready` are low exactly while the plug sequencer has events left to emit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error post valid |
| err_ready | output | 1 | Error post accepted this cycle |
| err_fh | input | 32 | Error function handle |
| err_fid | input | 32 | Error function id |
| err_code | input | 16 | Error event code |
| err_addr | input | 64 | Faulting address |
| err_qual | input | 32 | Qualifier word |
| hp_valid | input | 1 | Plug command valid |
| hp_ready | output | 1 | Plug command accepted this cycle |
| hp_attach | input | 1 | 1 = plug, 0 = unplug |
| hp_hot | input | 1 | Plug is a hot plug (posts events) |
| hp_slot | input | SLOT_W | Slot number |
| cfg_valid | input | 1 | Configure request strobe |
| cfg_on | input | 1 | 1 = configure, 0 = deconfigure |
| cfg_fid | input | 32 | Function id of the request |
| cfg_done | output | 1 | Configure response strobe |
| cfg_rc | output | 2 | Configure response code |
| pop_req | input | 1 | Host pop request |
| rsp_rc | output | 1 | 0 = record returned, 1 = queue was empty |
| rsp_class | output | 2 | Record class |
| rsp_fid | output | 32 | Record function id |
| rsp_fh | output | 32 | Record function handle |
| rsp_code | output | 16 | Record event code |
| rsp_addr | output | 64 | Record faulting address |
| rsp_qual | output | 32 | Record qualifier word |
| pending | output | 1 | Queue not empty |
| notify | output | 1 | One-cycle post notification |
| overflow | output | 1 | Sticky drop flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The assertions assume that a plug command and a configure request never address the same slot in the same cycle. They also assume that `ovf_clr` is never pulsed in the cycle a drop happens. Under those assumptions, the plug command's update of the slot state and the result of the flag are both unambiguous. The stimulus keeps plug and configure commands in separate cycles and pulses the clear only while the queue is idle. A requester holds `err_valid` and its fields stable until `err_ready` is seen. The bench therefore drives them at the falling edge and keeps them until a cycle in which ready was high.

// File: rtl/fevq_pkg.sv
package fevq_pkg;
  localparam logic [31:0] VIRT_FLAG = 32'h8000_0000;

  localparam logic [15:0] EV_RES_TO_STBY  = 16'h0302;
  localparam logic [15:0] EV_TO_CFG       = 16'h0301;
  localparam logic [15:0] EV_CFG_TO_STBRS = 16'h0304;
  localparam logic [15:0] EV_STBY_TO_RES  = 16'h0308;

  localparam logic [1:0] RC_DONE  = 2'd0;
  localparam logic [1:0] RC_NOOP  = 2'd1;
  localparam logic [1:0] RC_BADID = 2'd2;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ERR   = 2'd1,
    CLS_AVAIL = 2'd2
  } ev_class_e;

  typedef struct packed {
    ev_class_e   cls;
    logic [31:0] fid;
    logic [31:0] fh;
    logic [15:0] code;
    logic [63:0] addr;
    logic [31:0] qual;
  } ev_rec_t;
endpackage

// File: rtl/fevq_fifo.sv
module fevq_fifo
  import fevq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push_i,
  input  ev_rec_t rec_i,
  input  logic    pop_i,
  output logic    full_o,
  output logic    empty_o,
  output ev_rec_t head_o
);
  ev_rec_t       mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign head_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= rec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_i) wp <= bump(wp);
      if (pop_i)  rp <= bump(rp);
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (pop_i && !push_i) count <= count - 1'b1;
    end
  end

  // R1
  push_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (rec_i.cls == CLS_ERR || rec_i.cls == CLS_AVAIL));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !(push_i && !pop_i));

  // R10
  pushpop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(count));
endmodule

// File: rtl/fevq_slots.sv
module fevq_slots
  import fevq_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_valid_i,
  output logic              hp_ready_o,
  input  logic              hp_attach_i,
  input  logic              hp_hot_i,
  input  logic [SLOT_W-1:0] hp_slot_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_on_i,
  input  logic [31:0]       cfg_fid_i,
  output logic              cfg_done_o,
  output logic [1:0]        cfg_rc_o,
  output logic              ev_valid_o,
  output ev_rec_t           ev_o
);
  logic [31:0] fh_q  [SLOTS];
  logic [31:0] fid_q [SLOTS];
  logic        cfgd_q[SLOTS];

  logic              q0_v, q1_v;
  logic [15:0]       q0_code, q1_code;
  logic [31:0]       s_fh, s_fid;
  logic              hit;
  logic [SLOT_W-1:0] hit_idx;
  logic [1:0]        rc;
  logic              accept;
  logic [31:0]       new_id;

  assign hp_ready_o = !q0_v;
  assign accept     = hp_valid_i && hp_ready_o;
  assign new_id     = 32'(hp_slot_i);

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (fh_q[i] != '0 && fid_q[i] == cfg_fid_i) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(i);
      end
    end
    if (!hit)                          rc = RC_BADID;
    else if (cfgd_q[hit_idx] == cfg_on_i) rc = RC_NOOP;
    else                               rc = RC_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        fh_q[i]   <= '0;
        fid_q[i]  <= '0;
        cfgd_q[i] <= 1'b0;
      end
      q0_v <= 1'b0; q1_v <= 1'b0;
      q0_code <= '0; q1_code <= '0;
      s_fh <= '0; s_fid <= '0;
      cfg_done_o <= 1'b0;
      cfg_rc_o   <= RC_DONE;
    end else begin
      cfg_done_o <= cfg_valid_i;
      if (cfg_valid_i) cfg_rc_o <= rc;
      if (cfg_valid_i && rc == RC_DONE) cfgd_q[hit_idx] <= cfg_on_i;
      if (accept) begin
        if (hp_attach_i) begin
          fh_q[hp_slot_i]   <= new_id | VIRT_FLAG;
          fid_q[hp_slot_i]  <= new_id;
          cfgd_q[hp_slot_i] <= 1'b1;
          s_fh    <= new_id | VIRT_FLAG;
          s_fid   <= new_id;
          q0_v    <= hp_hot_i;
          q1_v    <= hp_hot_i;
          q0_code <= EV_RES_TO_STBY;
          q1_code <= EV_TO_CFG;
        end else begin
          s_fh  <= fh_q[hp_slot_i];
          s_fid <= fid_q[hp_slot_i];
          fh_q[hp_slot_i]   <= '0;
          fid_q[hp_slot_i]  <= '0;
          cfgd_q[hp_slot_i] <= 1'b0;
          q0_v    <= 1'b1;
          q1_v    <= cfgd_q[hp_slot_i];
          q0_code <= cfgd_q[hp_slot_i] ? EV_CFG_TO_STBRS : EV_STBY_TO_RES;
          q1_code <= EV_STBY_TO_RES;
        end
      end else if (q0_v) begin
        q0_v    <= q1_v;
        q0_code <= q1_code;
        q1_v    <= 1'b0;
      end
    end
  end

  assign ev_valid_o = q0_v;
  always_comb begin
    ev_o      = '0;
    ev_o.cls  = CLS_AVAIL;
    ev_o.fid  = s_fid;
    ev_o.fh   = s_fh;
    ev_o.code = q0_code;
  end

  // R5
  hot_plug_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hp_attach_i && hp_hot_i) |=> (ev_valid_o && ev_o.code == EV_RES_TO_STBY));

  // R5
  cold_plug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hp_attach_i && !hp_hot_i) |=> !ev_valid_o);

  // R7
  cfg_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_i |=> cfg_done_o);
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
  import fevq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [31:0]       err_fh,
  input  logic [31:0]       err_fid,
  input  logic [15:0]       err_code,
  input  logic [63:0]       err_addr,
  input  logic [31:0]       err_qual,
  input  logic              hp_valid,
  output logic              hp_ready,
  input  logic              hp_attach,
  input  logic              hp_hot,
  input  logic [SLOT_W-1:0] hp_slot,
  input  logic              cfg_valid,
  input  logic              cfg_on,
  input  logic [31:0]       cfg_fid,
  output logic              cfg_done,
  output logic [1:0]        cfg_rc,
  input  logic              pop_req,
  output logic              rsp_rc,
  output logic [1:0]        rsp_class,
  output logic [31:0]       rsp_fid,
  output logic [31:0]       rsp_fh,
  output logic [15:0]       rsp_code,
  output logic [63:0]       rsp_addr,
  output logic [31:0]       rsp_qual,
  output logic              pending,
  output logic              notify,
  output logic              overflow,
  input  logic              ovf_clr
);
  logic    seq_v, full, empty, post, pop_eff, push_ok, drop;
  ev_rec_t seq_rec, err_rec, post_rec, head, rsp_q;

  fevq_slots #(.SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .hp_valid_i(hp_valid), .hp_ready_o(hp_ready), .hp_attach_i(hp_attach),
    .hp_hot_i(hp_hot), .hp_slot_i(hp_slot),
    .cfg_valid_i(cfg_valid), .cfg_on_i(cfg_on), .cfg_fid_i(cfg_fid),
    .cfg_done_o(cfg_done), .cfg_rc_o(cfg_rc),
    .ev_valid_o(seq_v), .ev_o(seq_rec)
  );

  always_comb begin
    err_rec      = '0;
    err_rec.cls  = CLS_ERR;
    err_rec.fid  = err_fid;
    err_rec.fh   = err_fh;
    err_rec.code = err_code;
    err_rec.addr = err_addr;
    err_rec.qual = err_qual;
  end

  assign err_ready = !seq_v;
  assign post      = seq_v || err_valid;
  assign post_rec  = seq_v ? seq_rec : err_rec;
  assign pop_eff   = pop_req && !empty;
  assign push_ok   = post && (!full || pop_eff);
  assign drop      = post && !push_ok;

  fevq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_ok), .rec_i(post_rec), .pop_i(pop_eff),
    .full_o(full), .empty_o(empty), .head_o(head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q    <= '0;
      rsp_rc   <= 1'b1;
      notify   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      notify <= push_ok;
      if (drop)         overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
      if (pop_req) begin
        rsp_rc <= empty;
        if (!empty) rsp_q <= head;
      end
    end
  end

  assign pending   = !empty;
  assign rsp_class = rsp_q.cls;
  assign rsp_fid   = rsp_q.fid;
  assign rsp_fh    = rsp_q.fh;
  assign rsp_code  = rsp_q.code;
  assign rsp_addr  = rsp_q.addr;
  assign rsp_qual  = rsp_q.qual;

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pending) |=> (rsp_rc && $stable(rsp_fid) && $stable(rsp_fh)
                               && $stable(rsp_code) && $stable(rsp_addr)));

  // R4
  notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_ready && !full) |=> notify);

  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);

  // R11
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_ready |-> !err_ready);
endmodule

// File: tb/sim_fn_event_queue.sv
`timescale 1ns/1ps
module sim_fn_event_queue;
  localparam int DEPTH = 8;
  localparam int SLOTS = 4;

  typedef struct {
    int          cls;
    logic [31:0] fid, fh, qual;
    logic [15:0] code;
    logic [63:0] addr;
  } mrec_t;

  logic clk = 0, rst_n = 0;
  logic err_valid = 0, hp_valid = 0, hp_attach = 0, hp_hot = 0;
  logic [31:0] err_fh = 0, err_fid = 0, err_qual = 0, cfg_fid = 0;
  logic [15:0] err_code = 0;
  logic [63:0] err_addr = 0;
  logic [1:0]  hp_slot = 0;
  logic cfg_valid = 0, cfg_on = 0, pop_req = 0, ovf_clr = 0;
  logic err_ready, hp_ready, cfg_done, rsp_rc, pending, notify, overflow;
  logic [1:0]  cfg_rc, rsp_class;
  logic [31:0] rsp_fid, rsp_fh, rsp_qual;
  logic [15:0] rsp_code;
  logic [63:0] rsp_addr;

  fn_event_queue #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u0 (
    .clk, .rst_n, .err_valid, .err_ready, .err_fh, .err_fid, .err_code,
    .err_addr, .err_qual, .hp_valid, .hp_ready, .hp_attach, .hp_hot, .hp_slot,
    .cfg_valid, .cfg_on, .cfg_fid, .cfg_done, .cfg_rc, .pop_req, .rsp_rc,
    .rsp_class, .rsp_fid, .rsp_fh, .rsp_code, .rsp_addr, .rsp_qual,
    .pending, .notify, .overflow, .ovf_clr
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  mrec_t mq[$], pend[$];
  mrec_t e_rsp;
  logic  e_rc, e_notify, e_ovf, e_cdone;
  logic [1:0]  e_crc;
  logic [31:0] m_fh[SLOTS], m_fid[SLOTS];
  logic        m_cfg[SLOTS];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mq.delete(); pend.delete();
    e_rsp = '{cls: 0, fid: 0, fh: 0, qual: 0, code: 0, addr: 0};
    e_rc = 1; e_notify = 0; e_ovf = 0; e_cdone = 0; e_crc = 0;
    for (int i = 0; i < SLOTS; i++) begin m_fh[i] = 0; m_fid[i] = 0; m_cfg[i] = 0; end
  endtask

  initial model_reset();

  // behavioural reference, evaluated on inputs that were driven at the falling edge
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit    have, dropped, busy;
      mrec_t p;
      int    s, hit;
      busy = (pend.size() != 0);
      have = 0; dropped = 0;
      if (busy) begin p = pend.pop_front(); have = 1; end
      else if (err_valid) begin
        p = '{cls: 1, fid: err_fid, fh: err_fh, qual: err_qual, code: err_code, addr: err_addr};
        have = 1;
      end
      if (pop_req) begin
        if (mq.size() != 0) begin e_rsp = mq.pop_front(); e_rc = 0; end
        else e_rc = 1;
      end
      e_notify = 0;
      if (have) begin
        if (mq.size() < DEPTH) begin mq.push_back(p); e_notify = 1; end
        else dropped = 1;
      end
      if (dropped) e_ovf = 1; else if (ovf_clr) e_ovf = 0;
      e_cdone = cfg_valid;
      if (cfg_valid) begin
        hit = -1;
        for (int i = SLOTS - 1; i >= 0; i--)
          if (m_fh[i] != 0 && m_fid[i] == cfg_fid) hit = i;
        if (hit < 0) e_crc = 2;
        else if (m_cfg[hit] == cfg_on) e_crc = 1;
        else begin e_crc = 0; m_cfg[hit] = cfg_on; end
      end
      if (hp_valid && !busy) begin
        s = int'(hp_slot);
        if (hp_attach) begin
          m_fid[s] = s; m_fh[s] = 32'(s) | 32'h8000_0000; m_cfg[s] = 1;
          if (hp_hot) begin
            pend.push_back('{cls: 2, fid: m_fid[s], fh: m_fh[s], qual: 0, code: 16'h0302, addr: 0});
            pend.push_back('{cls: 2, fid: m_fid[s], fh: m_fh[s], qual: 0, code: 16'h0301, addr: 0});
          end
        end else begin
          if (m_cfg[s])
            pend.push_back('{cls: 2, fid: m_fid[s], fh: m_fh[s], qual: 0, code: 16'h0304, addr: 0});
          pend.push_back('{cls: 2, fid: m_fid[s], fh: m_fh[s], qual: 0, code: 16'h0308, addr: 0});
          m_fh[s] = 0; m_fid[s] = 0; m_cfg[s] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_class == 2'(e_rsp.cls), "R1", "rsp_class", 64'(rsp_class), 64'(e_rsp.cls));
      chk(rsp_fid == e_rsp.fid && rsp_fh == e_rsp.fh && rsp_code == e_rsp.code,
          "R2", "rsp_fid/fh/code", {rsp_fid, rsp_code, rsp_fh[15:0]},
          {e_rsp.fid, e_rsp.code, e_rsp.fh[15:0]});
      chk(rsp_addr == e_rsp.addr && rsp_qual == e_rsp.qual, "R2", "rsp_addr/qual",
          rsp_addr ^ 64'(rsp_qual), e_rsp.addr ^ 64'(e_rsp.qual));
      chk(rsp_rc == e_rc, "R3", "rsp_rc", 64'(rsp_rc), 64'(e_rc));
      chk(pending == (mq.size() != 0), "R3", "pending", 64'(pending), 64'(mq.size() != 0));
      chk(notify == e_notify, "R4", "notify", 64'(notify), 64'(e_notify));
      chk(overflow == e_ovf, "R9", "overflow", 64'(overflow), 64'(e_ovf));
      chk(cfg_done == e_cdone, "R7", "cfg_done", 64'(cfg_done), 64'(e_cdone));
      if (e_cdone) chk(cfg_rc == e_crc, "R7", "cfg_rc", 64'(cfg_rc), 64'(e_crc));
      chk(err_ready == (pend.size() == 0) && hp_ready == (pend.size() == 0), "R11",
          "err_ready/hp_ready", {err_ready, hp_ready}, {2{pend.size() == 0}});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    pop_req = 1; @(negedge clk); pop_req = 0;
  endtask

  task automatic plug(input bit attach, input bit hot, input logic [1:0] s);
    bit r;
    hp_valid = 1; hp_attach = attach; hp_hot = hot; hp_slot = s;
    forever begin r = hp_ready; @(negedge clk); if (r) break; end
    hp_valid = 0;
  endtask

  task automatic cfg(input bit on, input logic [31:0] id);
    cfg_valid = 1; cfg_on = on; cfg_fid = id; @(negedge clk); cfg_valid = 0;
  endtask

  task automatic post_err(input logic [31:0] id, input logic [63:0] a);
    bit r;
    err_valid = 1; err_fid = id; err_fh = id | 32'h8000_0000;
    err_code = 16'h0a00 + 16'(id); err_addr = a; err_qual = ~id;
    forever begin r = err_ready; @(negedge clk); if (r) break; end
    err_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_rc == 1 && pending == 0 && overflow == 0, "R3", "reset state",
        {rsp_rc, pending, overflow}, 3'b100);
    pop();                                   // empty pop, R3
    plug(1, 0, 2'd1); idle(3);               // cold attach, R5
    chk(pending == 0, "R5", "cold attach posts nothing", 64'(pending), 0);
    plug(1, 1, 2'd2); idle(3);               // hot plug
    pop();
    chk(rsp_code == 16'h0302 && rsp_fh == 32'h8000_0002 && rsp_fid == 2, "R5",
        "first hot plug event", {rsp_code, rsp_fh}, {16'h0302, 32'h8000_0002});
    pop();
    chk(rsp_code == 16'h0301, "R5", "second hot plug event", 64'(rsp_code), 64'h0301);
    cfg(1, 2); cfg(0, 2); cfg(0, 2); cfg(1, 9); idle(1);  // R7
    plug(0, 0, 2'd2); idle(2); pop();
    chk(rsp_code == 16'h0308 && rsp_fh == 32'h8000_0002, "R6",
        "unplug of unconfigured slot", {rsp_code, rsp_fh}, {16'h0308, 32'h8000_0002});
    pop();
    chk(rsp_rc == 1, "R6", "unplug posts one event only", 64'(rsp_rc), 1);
    cfg(1, 2);
    chk(cfg_rc == 2, "R8", "unplugged id unknown", 64'(cfg_rc), 2);
    plug(0, 0, 2'd1); idle(3);               // configured unplug
    pop(); pop(); pop();
    // error posts racing the sequencer, R11
    fork
      plug(1, 1, 2'd3);
      begin post_err(32'h11, 64'h1234_5678_9abc_def0); post_err(32'h12, 64'h55); end
    join
    idle(3);
    repeat (4) pop();
    // fill and overflow, R9
    for (int i = 0; i < DEPTH + 2; i++) post_err(32'h20 + i, 64'(i) << 12);
    chk(overflow == 1, "R9", "overflow after drop", 64'(overflow), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    // post and pop together while full, R10
    pop_req = 1; post_err(32'h40, 64'hdead); pop_req = 0;
    chk(overflow == 0 && pending == 1, "R10", "post with pop when full",
        {overflow, pending}, 2'b01);
    repeat (DEPTH + 1) pop();
    chk(rsp_rc == 1 && rsp_fid == 32'h40, "R10", "last record kept",
        {rsp_rc, rsp_fid}, {1'b1, 32'h40});
    post_err(32'h3, 64'h0); pop_req = 1; post_err(32'h4, 64'h8); pop_req = 0;
    idle(1); pop(); pop(); idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule